// File: doc/BRIEF.md
# Configurable Serial Audio Output Transmitter

This block turns parallel stereo PCM samples into a three-wire serial audio stream made of a bit clock, a left/right word clock and a serial data line. Everything runs from one fast PCM reference clock. The bit clock comes from a programmable divider on that clock. Each frame has two halves of 32 bit-clock slots, with the left channel first. Within each half the framing logic places a programmable number of data bits. A slot that carries no data bit is driven low.

Software sets the output format through a byte-wide write port. The programmable settings are the divider, the word length, the edge on which data changes, the word-clock sense, standard versus justified framing, the justification side, the bit order and a channel routing mode. A master enable chooses between the programmed values and a fixed default set. The block samples the active settings and the next sample pair together, once per frame at the frame boundary. It pulses a ready strobe to ask for the following pair.

Top module: `audio_serial_tx`

## Requirements
- R1: The bit clock period is 2×(DIV+1) reference-clock cycles. DIV is the 6-bit value written to address 0x67, bits [5:0].
- R2: All registers reset to 0. While bit 0 of address 0x66 is 0, the programmed values are ignored and the block behaves as if DIV=3, format=0 and routing=0.
- R3: Format bits [1:0] at address 0x68 select 16, 18, 20 or 24 data bits per channel for codes 0 to 3. The bits sent are the most significant N bits of the 24-bit sample input.
- R4: With format bit 2 at 0, data changes on the falling bit-clock edge and is stable at the rising edge. With bit 2 at 1, the edges are reversed.
- R5: Each frame is 64 bit-clock slots, left half first. With format bit 4 at 0 the word clock is high for the left half. With bit 4 at 1 it is low for the left half.
- R6: With format bit 3 at 0 (I2S framing), the first data bit occupies slot 1 of each half and bit 5 is ignored. With bit 3 at 1, bit 5 at 1 starts the data in slot 0, and bit 5 at 0 ends the data in slot 31.
- R7: Format bit 6 at 0 sends the least significant transmitted bit first. At 1 it sends the most significant bit first.
- R8: Slots outside the data window of a half frame are driven low.
- R9: Routing bits [1:0] at address 0x69 select the channel sources. Code 0 sends left/right normally, 1 swaps the channels, 2 sends left on both, and 3 sends right on both.
- R10: At each frame boundary the block captures the sample pair if the valid input is high, or a pair of zeros otherwise. It then raises the ready output for exactly one reference-clock cycle.
- R11: Register writes made during a frame do not change that frame. They take effect from the next frame boundary.
- R12: After reset, before the first frame starts, the bit clock is high, the word clock is low, and the data and ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| smp_valid | input | 1 | Sample pair on the inputs is valid |
| smp_left | input | 24 | Left sample, MSB aligned |
| smp_right | input | 24 | Right sample, MSB aligned |
| smp_ready | output | 1 | One-cycle pulse after a pair was captured |
| bclk | output | 1 | Serial bit clock |
| wclk | output | 1 | Left/right word clock |
| sdata | output | 1 | Serial data |

## Verification
The embedded properties assume a few things about the inputs: reset is held until the reference clock runs, and the sample inputs and register writes change only on reference-clock edges. Under these assumptions, data and word clock can move only when the bit clock is at its launch level, and the active configuration changes only at a frame start. The stimulus meets them by driving all inputs at the falling reference-clock edge. It issues register writes only right after a ready pulse, so a whole frame separates a write from the boundary that applies it. The mid-frame write case is the one intended exception.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

   localparam int DIV_W = 6;
   localparam int FMT_W = 7;
   localparam int XR_W  = 2;

   typedef struct packed {
      logic [DIV_W-1:0] div;
      logic [XR_W-1:0]  xroute;
      logic             msb_first;
      logic             left_just;
      logic             wclk_pol;
      logic             alt_fmt;
      logic             bclk_pol;
      logic [1:0]       wlen;
   } cfg_t;

   localparam cfg_t CFG_DEFAULT = '{div: 6'd3, xroute: 2'd0, msb_first: 1'b0,
                                    left_just: 1'b0, wclk_pol: 1'b0, alt_fmt: 1'b0,
                                    bclk_pol: 1'b0, wlen: 2'd0};

   function automatic int word_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 18;
         2'd2:    return 20;
         default: return 24;
      endcase
   endfunction

   function automatic cfg_t decode_cfg(input logic [DIV_W-1:0] div_f,
                                       input logic [FMT_W-1:0] fmt_f,
                                       input logic [XR_W-1:0]  xr_f);
      cfg_t c;
      c.div       = div_f;
      c.xroute    = xr_f;
      c.wlen      = fmt_f[1:0];
      c.bclk_pol  = fmt_f[2];
      c.alt_fmt   = fmt_f[3];
      c.wclk_pol  = fmt_f[4];
      c.left_just = fmt_f[5];
      c.msb_first = fmt_f[6];
      return c;
   endfunction

endpackage

// File: rtl/aud_tx_regs.sv
module aud_tx_regs
   import aud_tx_pkg::*;
#(
   parameter int              ADDR_W   = 8,
   parameter int              DATA_W   = 8,
   parameter logic [ADDR_W-1:0] ADDR_EN  = 8'h66,
   parameter logic [ADDR_W-1:0] ADDR_DIV = 8'h67,
   parameter logic [ADDR_W-1:0] ADDR_FMT = 8'h68,
   parameter logic [ADDR_W-1:0] ADDR_XR  = 8'h69
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output cfg_t              cfg_eff
);

   localparam int NREG = 4;

   if (DATA_W < FMT_W) begin : g_chk_data
      $error("aud_tx_regs: DATA_W must hold the widest field");
   end
   if (ADDR_W < 1) begin : g_chk_addr
      $error("aud_tx_regs: ADDR_W must be positive");
   end

   logic                 en_f;
   logic [DIV_W-1:0]     div_f;
   logic [FMT_W-1:0]     fmt_f;
   logic [XR_W-1:0]      xr_f;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam int FW = (g == 0) ? 1 : (g == 1) ? DIV_W : (g == 2) ? FMT_W : XR_W;
      localparam logic [ADDR_W-1:0] MY_ADDR =
         (g == 0) ? ADDR_EN : (g == 1) ? ADDR_DIV : (g == 2) ? ADDR_FMT : ADDR_XR;
      logic [FW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_addr == MY_ADDR)) begin
            q <= wr_data[FW-1:0];
         end
      end
   end

   assign en_f  = g_reg[0].q;
   assign div_f = g_reg[1].q;
   assign fmt_f = g_reg[2].q;
   assign xr_f  = g_reg[3].q;

   always_comb begin
      if (en_f) cfg_eff = decode_cfg(div_f, fmt_f, xr_f);
      else      cfg_eff = CFG_DEFAULT;
   end

endmodule

// File: rtl/aud_tx_bitclk.sv
module aud_tx_bitclk
   import aud_tx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             launch,
   output logic             ph
);

   logic [DIV_W-1:0] cnt_q;
   logic             tick;

   assign tick   = (cnt_q == div);
   assign launch = tick & ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ph    <= 1'b1;
      end else if (tick) begin
         cnt_q <= '0;
         ph    <= ~ph;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1: the divider never runs past the active ratio, even across a frame-boundary ratio change
   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= div);

endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
   import aud_tx_pkg::*;
#(
   parameter int SAMPLE_W   = 24,
   parameter int HALF_SLOTS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                launch,
   input  cfg_t                cfg_eff,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   output cfg_t                cfg_act,
   output logic                smp_ready,
   output logic                wclk,
   output logic                sdata
);

   localparam int SLOT_W = $clog2(2 * HALF_SLOTS);
   localparam int POS_W  = SLOT_W - 1;

   if (SAMPLE_W < 24) begin : g_chk_w
      $error("aud_tx_framer: SAMPLE_W must hold a 24-bit word");
   end
   if (HALF_SLOTS < 25 || (HALF_SLOTS & (HALF_SLOTS - 1)) != 0) begin : g_chk_slots
      $error("aud_tx_framer: HALF_SLOTS must be a power of two of at least 25");
   end

   logic [SLOT_W-1:0]   slot_q;
   logic [SAMPLE_W-1:0] word_l_q, word_r_q;
   logic [SAMPLE_W-1:0] pick_l, pick_r;
   logic                frame_start;
   logic                half;
   logic [POS_W-1:0]    pos;

   assign frame_start = launch && (slot_q == '1);
   assign half        = slot_q[SLOT_W-1];
   assign pos         = slot_q[POS_W-1:0];

   always_comb begin
      case (cfg_eff.xroute)
         2'd0:    begin pick_l = smp_left;  pick_r = smp_right; end
         2'd1:    begin pick_l = smp_right; pick_r = smp_left;  end
         2'd2:    begin pick_l = smp_left;  pick_r = smp_left;  end
         default: begin pick_l = smp_right; pick_r = smp_right; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q    <= '1;
         cfg_act   <= CFG_DEFAULT;
         word_l_q  <= '0;
         word_r_q  <= '0;
         smp_ready <= 1'b0;
      end else begin
         smp_ready <= frame_start;
         if (launch) slot_q <= slot_q + 1'b1;
         if (frame_start) begin
            cfg_act  <= cfg_eff;
            word_l_q <= smp_valid ? pick_l : '0;
            word_r_q <= smp_valid ? pick_r : '0;
         end
      end
   end

   assign wclk = half ^ ~cfg_act.wclk_pol;

   always_comb begin
      int nb, st, k, idx;
      logic in_win;
      logic [SAMPLE_W-1:0] w;
      w  = half ? word_r_q : word_l_q;
      nb = word_bits(cfg_act.wlen);
      if (!cfg_act.alt_fmt)      st = 1;
      else if (cfg_act.left_just) st = 0;
      else                        st = HALF_SLOTS - nb;
      k      = int'(pos) - st;
      in_win = (k >= 0) && (k < nb);
      idx    = cfg_act.msb_first ? (SAMPLE_W - 1 - k) : (SAMPLE_W - nb + k);
      if (!in_win) idx = 0;
      sdata  = in_win & w[idx];
   end

   // R11: active settings move only on a frame boundary
   a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(cfg_act));
   // R10: ready never lasts more than one cycle
   a_r10_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
      smp_ready |=> !smp_ready);
   // R10: ready follows a boundary capture only
   a_r10_ready_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      smp_ready |-> (slot_q == '0));

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
   import aud_tx_pkg::*;
#(
   parameter int                SAMPLE_W   = 24,
   parameter int                HALF_SLOTS = 32,
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] ADDR_EN    = 8'h66,
   parameter logic [ADDR_W-1:0] ADDR_DIV   = 8'h67,
   parameter logic [ADDR_W-1:0] ADDR_FMT   = 8'h68,
   parameter logic [ADDR_W-1:0] ADDR_XR    = 8'h69
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   output logic                smp_ready,
   output logic                bclk,
   output logic                wclk,
   output logic                sdata
);

   cfg_t cfg_eff, cfg_act;
   logic launch, ph;

   aud_tx_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_EN(ADDR_EN),
      .ADDR_DIV(ADDR_DIV), .ADDR_FMT(ADDR_FMT), .ADDR_XR(ADDR_XR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cfg_eff(cfg_eff)
   );

   aud_tx_bitclk u_bitclk (
      .clk(clk), .rst_n(rst_n), .div(cfg_act.div), .launch(launch), .ph(ph)
   );

   aud_tx_framer #(
      .SAMPLE_W(SAMPLE_W), .HALF_SLOTS(HALF_SLOTS)
   ) u_framer (
      .clk(clk), .rst_n(rst_n), .launch(launch), .cfg_eff(cfg_eff),
      .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
      .cfg_act(cfg_act), .smp_ready(smp_ready), .wclk(wclk), .sdata(sdata)
   );

   assign bclk = ph ^ cfg_act.bclk_pol;

   // R4: serial data moves only while the bit clock sits at its launch level
   a_r4_sdata_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdata) |-> (bclk == cfg_act.bclk_pol));
   // R5: the word clock moves only on a launch edge
   a_r5_wclk_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wclk) |-> (bclk == cfg_act.bclk_pol));

endmodule

// File: tb/audio_serial_tx_tb.sv
module audio_serial_tx_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   typedef struct packed {
      logic        en;
      logic [5:0]  div;
      logic [6:0]  fmt;
      logic [1:0]  xr;
      logic [23:0] l;
      logic [23:0] r;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 6'd0,  7'h00, 2'd0, 24'hA5C3F1, 24'h3C5A96},
      '{1'b1, 6'd1,  7'h7F, 2'd1, 24'h123456, 24'hFEDCBA},
      '{1'b1, 6'd2,  7'h49, 2'd2, 24'hC0FFEE, 24'h0BADF0},
      '{1'b1, 6'd0,  7'h1A, 2'd3, 24'h81422C, 24'h7E5D13},
      '{1'b0, 6'd5,  7'h7F, 2'd1, 24'hF0F00F, 24'h0A0B0C},
      '{1'b1, 6'd3,  7'h62, 2'd0, 24'h9ABCDE, 24'h135799},
      '{1'b1, 6'd1,  7'h57, 2'd0, 24'hD00D1E, 24'h55AA33},
      '{1'b1, 6'd63, 7'h2C, 2'd0, 24'h6E3C81, 24'hB1E024}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        smp_valid = 1'b0;
   logic [23:0] smp_left = '0;
   logic [23:0] smp_right = '0;
   logic        smp_ready, bclk, wclk, sdata;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   audio_serial_tx u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .smp_valid(smp_valid), .smp_left(smp_left),
      .smp_right(smp_right), .smp_ready(smp_ready), .bclk(bclk),
      .wclk(wclk), .sdata(sdata)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic apply(input vec_t v);
      smp_left  = v.l;
      smp_right = v.r;
      wr(8'h66, {7'd0, v.en});
      wr(8'h67, {2'd0, v.div});
      wr(8'h68, {1'b0, v.fmt});
      wr(8'h69, {6'd0, v.xr});
   endtask

   task automatic wait_ready();
      @(negedge clk);
      while (!smp_ready) @(negedge clk);
   endtask

   // expected frame from the requirements (R2, R3, R5 to R9)
   task automatic build(input vec_t v, input logic valid,
                        output logic [63:0] d, output logic [63:0] w);
      logic [6:0]  f;
      logic [1:0]  xr;
      logic [23:0] wl, wrt, smp;
      int nb, st, k;
      f  = v.en ? v.fmt : 7'h00;
      xr = v.en ? v.xr  : 2'd0;
      case (xr)
         2'd0:    begin wl = v.l; wrt = v.r; end
         2'd1:    begin wl = v.r; wrt = v.l; end
         2'd2:    begin wl = v.l; wrt = v.l; end
         default: begin wl = v.r; wrt = v.r; end
      endcase
      if (!valid) begin wl = '0; wrt = '0; end
      case (f[1:0])
         2'd0: nb = 16; 2'd1: nb = 18; 2'd2: nb = 20; default: nb = 24;
      endcase
      st = !f[3] ? 1 : (f[5] ? 0 : 32 - nb);
      for (int s = 0; s < 64; s++) begin
         smp  = (s >= 32) ? wrt : wl;
         w[s] = (s >= 32) ^ ~f[4];
         k    = (s % 32) - st;
         if (k < 0 || k >= nb) d[s] = 1'b0;
         else d[s] = f[6] ? smp[23 - k] : smp[24 - nb + k];
      end
   endtask

   task automatic capture(input logic pol, output logic [63:0] d,
                          output logic [63:0] w, output int per);
      logic prev;
      int n, c, c0;
      n = 0; c = 0; c0 = 0; per = 0;
      prev = bclk;
      while (n < 64) begin
         @(negedge clk);
         c++;
         if (bclk != prev && bclk == ~pol) begin
            d[n] = sdata;
            w[n] = wclk;
            if (n == 0) c0 = c;
            if (n == 1) per = c - c0;
            n++;
         end
         prev = bclk;
      end
   endtask

   task automatic check_frame(input string tag, input vec_t v, input logic valid);
      logic [63:0] d, w, ed, ew;
      int per, eper;
      logic pol;
      pol  = v.en ? v.fmt[2] : 1'b0;
      eper = 2 * ((v.en ? int'(v.div) : 3) + 1);
      build(v, valid, ed, ew);
      capture(pol, d, w, per);
      chk({tag, " R3/R4/R6/R7/R8/R9 data"}, d, ed);
      chk({tag, " R5 word clock"}, w, ew);
      chk({tag, " R1 bit clock period"}, 64'(per), 64'(eper));
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      vec_t dflt;
      smp_left = 24'h5A5A0F; smp_right = 24'hC3A1E7; smp_valid = 1'b1;
      repeat (3) @(negedge clk);
      // R12: outputs idle in reset and before the first frame
      chk("R12 reset outputs", {60'd0, bclk, wclk, sdata, smp_ready}, 64'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 idle after release", {60'd0, bclk, wclk, sdata, smp_ready}, 64'b1000);

      // R2: registers reset to zero, so the default set runs
      dflt = '{1'b0, 6'd0, 7'h00, 2'd0, 24'h5A5A0F, 24'hC3A1E7};
      wait_ready();
      check_frame("R2 default after reset", dflt, 1'b1);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         wait_ready();
         apply(VECS[i]);
         wait_ready();
         check_frame($sformatf("vec%0d", i), VECS[i], 1'b1);
      end

      // R11: a write during a frame leaves that frame alone
      wait_ready();
      apply(VECS[0]);
      check_frame("R11 old settings kept mid-frame", VECS[NVEC-1], 1'b1);
      wait_ready();
      check_frame("R11 new settings at boundary", VECS[0], 1'b1);

      // R10: invalid pair sends silence, and ready lasts one cycle
      smp_valid = 1'b0;
      wait_ready();
      @(negedge clk);
      chk("R10 ready single cycle", 64'(smp_ready), 64'd0);
      wait_ready();
      check_frame("R10 invalid pair zeros", VECS[0], 1'b0);
      smp_valid = 1'b1;
      wait_ready();
      check_frame("R10 valid pair again", VECS[0], 1'b1);

      // R2: enable cleared again falls back to defaults, ignoring the programmed values
      wait_ready();
      wr(8'h66, 8'h00);
      wait_ready();
      check_frame("R2 enable cleared", '{1'b0, 6'd0, 7'h00, 2'd0, VECS[0].l, VECS[0].r}, 1'b1);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule